// File: doc/BRIEF.md
# DDR3 Command Interpreter and Bank State Tracker

This block sits on the device side of a DDR3-style command and address bus. At each rising clock edge it samples the chip-select, the three command strobes, the bank address, the address bus, clock enable and the termination request. It turns them into a decoded command plus its operands. The decoded command is one of activate, read, write, precharge, refresh, mode-register write or no-operation.

The block keeps an open flag and an open-row register for each bank. It also checks each command against that bank state. For reads and writes it reports the column, the burst length and the auto-precharge flag. It classifies every low-clock-enable period as precharge power-down, active power-down or self-refresh. It gates the termination request with the enable that was last programmed through a mode-register write. It also flags a clock-enable drop that falls inside a data burst.

All outputs are registered. They show the result of the command sampled at the previous rising edge.

Top module: `ddr3_cmd_tracker`

## Requirements
- R1: When cs_ni is sampled high, the cycle is a no-operation: cmd_o becomes 0 and no bank state changes.
- R2: Strobes {ras_ni,cas_ni,we_ni} decode as 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode write, 111 and 110 no-operation. cmd_o reports 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode write, 0 no-operation. bank_o carries ba_i for every command except refresh and no-operation, and is 0 for those two.
- R3: An activate sets the bank's bank_open_o bit and stores all 16 address bits as its row. open_row_o always shows the stored row of the bank on bank_o.
- R4: A read or write reports col_o = addr_i[9:0] and auto_pre_o = addr_i[10]. When addr_i[10] is set, the bank closes in the same update.
- R5: burst_len_o is 8 when a read or write has addr_i[12] high, 4 when it has addr_i[12] low, and 0 for every other command.
- R6: A precharge with addr_i[10] low closes only bank ba_i. With addr_i[10] high it closes every bank. A precharge to a closed bank is legal.
- R7: Each of these raises proto_err_o for one cycle and leaves all bank state unchanged: an activate to an open bank, a read or write to a closed bank, and a refresh while any bank is open.
- R8: When cke_i is first sampled low, pwr_mode_o becomes 1 (precharge power-down) if no bank is open and 2 (active power-down) if any bank is open. The mode holds while cke_i stays low and returns to 0 at the first high sample.
- R9: A refresh sampled together with the first low cke_i enters self-refresh (pwr_mode_o = 3) only when all banks are idle. If a bank is open, the refresh is an error under R7 and the mode becomes active power-down.
- R10: Any command sampled with cke_i low is ignored (cmd_o = 0, state unchanged), except the refresh that enters self-refresh.
- R11: odt_en_o follows the previous edge's odt_i only while termination is enabled. A mode write to register 1 enables it when any of addr_i bits 2, 6 or 9 is set and disables it when all three are clear. Mode writes to other registers leave it alone. Termination is disabled after reset.
- R12: An accepted read or write opens an access window. The window covers the next 4 edges for a full burst and the next 2 edges for a chopped burst. A low cke_i sampled inside that window raises cke_err_o for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, commands sampled on rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write strobe, active low |
| cke_i | input | 1 | Clock enable |
| ba_i | input | 3 | Bank address or mode-register index |
| addr_i | input | 16 | Row, column, flags or mode-register data |
| odt_i | input | 1 | Termination request |
| cmd_o | output | 3 | Decoded command code |
| bank_o | output | 3 | Bank or register addressed by the command |
| col_o | output | 10 | Column of a read or write |
| burst_len_o | output | 4 | Burst length of a read or write, else 0 |
| auto_pre_o | output | 1 | Read or write closes its bank |
| bank_open_o | output | 8 | Open flag per bank |
| open_row_o | output | 16 | Stored row of the bank on bank_o |
| pwr_mode_o | output | 2 | 0 active, 1 precharge power-down, 2 active power-down, 3 self-refresh |
| odt_en_o | output | 1 | Gated termination enable |
| proto_err_o | output | 1 | Illegal command against bank state |
| cke_err_o | output | 1 | Clock enable dropped during an access |

## Verification
The bench sends the same strobe patterns once with chip select low and once high. This separates true decoding from masking. Column commands cover both settings of address bits 10 and 12, so burst length, auto-precharge close and the access-window length are each seen in both values. Clock-enable drops are made with all banks idle, with a bank open, and together with a refresh in each of those states. This separates the two power-down types from self-refresh and from the refused self-refresh. Mode writes go to register 1 with the termination bits set and then clear, and to another register with the same data, which shows which mode writes gate the termination request.

// File: rtl/ddr3_trk_pkg.sv
package ddr3_trk_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0, CMD_ACT = 3'd1, CMD_RD = 3'd2, CMD_WR = 3'd3,
    CMD_PRE = 3'd4, CMD_REF = 3'd5, CMD_MRS = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_ON = 2'd0, PWR_PPD = 2'd1, PWR_APD = 2'd2, PWR_SREF = 2'd3
  } pwr_e;

  localparam int unsigned BL_FULL = 8;
  localparam int unsigned BL_CHOP = 4;
  localparam int unsigned AP_BIT  = 10;  // auto-precharge / precharge-all
  localparam int unsigned BC_BIT  = 12;  // high = no chop
  localparam int unsigned MR_TERM = 1;   // register holding termination setting

  function automatic cmd_e strobe_decode(input logic [2:0] s);
    case (s)
      3'b011:  return CMD_ACT;
      3'b101:  return CMD_RD;
      3'b100:  return CMD_WR;
      3'b010:  return CMD_PRE;
      3'b001:  return CMD_REF;
      3'b000:  return CMD_MRS;
      default: return CMD_NOP;
    endcase
  endfunction
endpackage

// File: rtl/ddr3_cmd_decode.sv
module ddr3_cmd_decode
  import ddr3_trk_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic cke_i,
  input  logic cke_prev_i,
  output cmd_e cmd_o,
  output logic ref_req_o
);
  logic valid;

  assign ref_req_o = !cs_ni && ({ras_ni, cas_ni, we_ni} == 3'b001);
  // with cke low only the self-refresh entry refresh gets through
  assign valid     = !cs_ni && (cke_i || (cke_prev_i && ref_req_o));
  assign cmd_o     = valid ? strobe_decode({ras_ni, cas_ni, we_ni}) : CMD_NOP;
endmodule

// File: rtl/ddr3_bank_table.sv
module ddr3_bank_table
  import ddr3_trk_pkg::*;
#(
  parameter  int NUM_BANKS = 8,
  parameter  int ROW_W     = 16,
  localparam int BA_W      = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  cmd_e                 cmd_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic [ROW_W-1:0]     addr_i,
  input  logic [BA_W-1:0]      rd_bank_i,
  output logic [NUM_BANKS-1:0] open_o,
  output logic [ROW_W-1:0]     rd_row_o,
  output logic                 err_o
);
  logic [NUM_BANKS-1:0][ROW_W-1:0] rows;
  logic is_col;

  assign is_col = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);
  assign err_o  = ((cmd_i == CMD_ACT) && open_o[ba_i])
               || (is_col && !open_o[ba_i])
               || ((cmd_i == CMD_REF) && (|open_o));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             hit;
    logic             open_q;
    logic [ROW_W-1:0] row_q;

    assign hit       = (ba_i == BA_W'(b));
    assign open_o[b] = open_q;
    assign rows[b]   = row_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else if (!err_o) begin
        case (cmd_i)
          CMD_ACT: if (hit) begin
            open_q <= 1'b1;
            row_q  <= addr_i;
          end
          CMD_RD, CMD_WR: if (hit && addr_i[AP_BIT]) open_q <= 1'b0;
          CMD_PRE: if (hit || addr_i[AP_BIT]) open_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assign rd_row_o = rows[rd_bank_i];
endmodule

// File: rtl/ddr3_pwr_ctrl.sv
module ddr3_pwr_ctrl
  import ddr3_trk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cke_i,
  input  logic ref_req_i,
  input  logic all_idle_i,
  input  logic col_ok_i,
  input  logic chop_i,
  output pwr_e mode_o,
  output logic cke_prev_o,
  output logic cke_err_o
);
  localparam int unsigned CNT_W = $clog2(BL_FULL / 2 + 1);

  logic [CNT_W-1:0] busy_q;
  pwr_e             mode_d;

  always_comb begin
    mode_d = mode_o;
    if (cke_i)           mode_d = PWR_ON;
    else if (cke_prev_o) begin
      if (ref_req_i && all_idle_i) mode_d = PWR_SREF;
      else if (all_idle_i)         mode_d = PWR_PPD;
      else                         mode_d = PWR_APD;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o     <= PWR_ON;
      cke_prev_o <= 1'b1;
      cke_err_o  <= 1'b0;
      busy_q     <= '0;
    end else begin
      mode_o     <= mode_d;
      cke_prev_o <= cke_i;
      cke_err_o  <= (busy_q != '0) && !cke_i;
      if (col_ok_i)
        busy_q <= chop_i ? CNT_W'(BL_CHOP / 2) : CNT_W'(BL_FULL / 2);
      else if (busy_q != '0)
        busy_q <= busy_q - 1'b1;
    end
  end
endmodule

// File: rtl/ddr3_cmd_tracker.sv
module ddr3_cmd_tracker
  import ddr3_trk_pkg::*;
#(
  parameter  int NUM_BANKS = 8,
  parameter  int ROW_W     = 16,
  parameter  int COL_W     = 10,
  localparam int BA_W      = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 ras_ni,
  input  logic                 cas_ni,
  input  logic                 we_ni,
  input  logic                 cke_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic [ROW_W-1:0]     addr_i,
  input  logic                 odt_i,
  output logic [2:0]           cmd_o,
  output logic [BA_W-1:0]      bank_o,
  output logic [COL_W-1:0]     col_o,
  output logic [3:0]           burst_len_o,
  output logic                 auto_pre_o,
  output logic [NUM_BANKS-1:0] bank_open_o,
  output logic [ROW_W-1:0]     open_row_o,
  output logic [1:0]           pwr_mode_o,
  output logic                 odt_en_o,
  output logic                 proto_err_o,
  output logic                 cke_err_o
);
  cmd_e cmd;
  pwr_e mode;
  logic ref_req, cke_prev, err, is_col, term_on_q;

  ddr3_cmd_decode u_dec (
    .cs_ni, .ras_ni, .cas_ni, .we_ni, .cke_i,
    .cke_prev_i (cke_prev),
    .cmd_o      (cmd),
    .ref_req_o  (ref_req)
  );

  ddr3_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_banks (
    .clk_i, .rst_ni,
    .cmd_i     (cmd),
    .ba_i,
    .addr_i,
    .rd_bank_i (bank_o),
    .open_o    (bank_open_o),
    .rd_row_o  (open_row_o),
    .err_o     (err)
  );

  ddr3_pwr_ctrl u_pwr (
    .clk_i, .rst_ni, .cke_i,
    .ref_req_i  (ref_req),
    .all_idle_i (~|bank_open_o),
    .col_ok_i   (is_col && !err),
    .chop_i     (!addr_i[BC_BIT]),
    .mode_o     (mode),
    .cke_prev_o (cke_prev),
    .cke_err_o
  );

  assign is_col     = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign pwr_mode_o = mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o       <= CMD_NOP;
      bank_o      <= '0;
      col_o       <= '0;
      burst_len_o <= '0;
      auto_pre_o  <= 1'b0;
      proto_err_o <= 1'b0;
      odt_en_o    <= 1'b0;
      term_on_q   <= 1'b0;
    end else begin
      cmd_o       <= cmd;
      bank_o      <= (cmd == CMD_NOP || cmd == CMD_REF) ? '0 : ba_i;
      col_o       <= is_col ? addr_i[COL_W-1:0] : '0;
      burst_len_o <= !is_col ? 4'd0 : addr_i[BC_BIT] ? 4'(BL_FULL) : 4'(BL_CHOP);
      auto_pre_o  <= is_col && addr_i[AP_BIT];
      proto_err_o <= err;
      odt_en_o    <= odt_i && term_on_q;
      if (cmd == CMD_MRS && ba_i == BA_W'(MR_TERM))
        term_on_q <= addr_i[9] || addr_i[6] || addr_i[2];
    end
  end
endmodule

// File: rtl/ddr3_cmd_tracker_chk.sv
module ddr3_cmd_tracker_chk
  import ddr3_trk_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cs_ni,
  input logic                 cke_i,
  input logic                 odt_i,
  input logic [2:0]           cmd_o,
  input logic [3:0]           burst_len_o,
  input logic [NUM_BANKS-1:0] bank_open_o,
  input logic [1:0]           pwr_mode_o,
  input logic                 odt_en_o,
  input logic                 proto_err_o
);
  logic cke_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cke_seen_q <= 1'b1;
    else         cke_seen_q <= cke_i;

  a_r1_cs_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (cmd_o == 3'(CMD_NOP)) && $stable(bank_open_o));

  a_r5_burst_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'(CMD_RD) || cmd_o == 3'(CMD_WR)) |->
      (burst_len_o == 4'(BL_FULL) || burst_len_o == 4'(BL_CHOP)));

  a_r5_burst_other: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_o == 3'(CMD_RD) || cmd_o == 3'(CMD_WR)) |-> burst_len_o == 4'd0);

  a_r7_err_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> $stable(bank_open_o));

  a_r9_sref_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_mode_o == 2'(PWR_SREF)) |-> (bank_open_o == '0));

  a_r10_cke_low_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_i && !cke_seen_q) |=> (cmd_o == 3'(CMD_NOP)) && $stable(bank_open_o));

  a_r11_odt_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odt_en_o |-> $past(odt_i));
endmodule

bind ddr3_cmd_tracker ddr3_cmd_tracker_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (.*);

// File: tb/ddr3_cmd_tracker_test.sv
`timescale 1ns/1ps
module ddr3_cmd_tracker_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1, odt = 1'b0;
  logic [2:0]  ba = '0;
  logic [15:0] addr = '0;
  logic [2:0]  cmd, bank;
  logic [9:0]  col;
  logic [3:0]  blen;
  logic        ap, odt_en, perr, ckerr;
  logic [7:0]  bopen;
  logic [15:0] orow;
  logic [1:0]  pmode;

  always #2.5 clk = ~clk;

  ddr3_cmd_tracker uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .cke_i(cke), .ba_i(ba), .addr_i(addr), .odt_i(odt),
    .cmd_o(cmd), .bank_o(bank), .col_o(col), .burst_len_o(blen), .auto_pre_o(ap),
    .bank_open_o(bopen), .open_row_o(orow), .pwr_mode_o(pmode), .odt_en_o(odt_en),
    .proto_err_o(perr), .cke_err_o(ckerr)
  );

  typedef struct {
    int cmd, bank, col, bl, ap, bopen, orow, mode, odt, perr, ckerr;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  bit [7:0]  m_open = '0;
  bit [15:0] m_row [8] = '{default: '0};
  bit        m_term = 0, m_ckep = 1;
  int        m_mode = 0, m_busy = 0;

  localparam bit [2:0] S_ACT = 3'b011, S_RD = 3'b101, S_WR = 3'b100, S_PRE = 3'b010,
                       S_REF = 3'b001, S_MRS = 3'b000, S_NOP = 3'b111, S_ZQ = 3'b110;

  function automatic int code_of(bit [2:0] s);
    case (s)
      S_ACT: return 1; S_RD: return 2; S_WR: return 3; S_PRE: return 4;
      S_REF: return 5; S_MRS: return 6; default: return 0;
    endcase
  endfunction

  task automatic drive(string tag, bit c_n, bit [2:0] s, bit [2:0] b, bit [15:0] a,
                       bit ck, bit od);
    exp_t e;
    bit ref_req, valid, err, idle, col_cmd;
    int c;
    @(negedge clk);
    cs_n = c_n; {ras_n, cas_n, we_n} = s; ba = b; addr = a; cke = ck; odt = od;
    ref_req = !c_n && s == S_REF;
    valid   = !c_n && (ck || (m_ckep && ref_req));
    c       = valid ? code_of(s) : 0;
    col_cmd = (c == 2 || c == 3);
    idle    = (m_open == 0);
    err     = (c == 1 && m_open[b]) || (col_cmd && !m_open[b]) || (c == 5 && !idle);
    if (ck) m_mode = 0;
    else if (m_ckep) m_mode = (ref_req && idle) ? 3 : idle ? 1 : 2;
    e.ckerr = (m_busy != 0 && !ck);
    if (col_cmd && !err) m_busy = a[12] ? 4 : 2;
    else if (m_busy != 0) m_busy--;
    if (!err) begin
      if (c == 1) begin m_open[b] = 1; m_row[b] = a; end
      if (col_cmd && a[10]) m_open[b] = 0;
      if (c == 4) begin if (a[10]) m_open = '0; else m_open[b] = 0; end
    end
    e.cmd = c; e.bank = (c == 0 || c == 5) ? 0 : b;
    e.col = col_cmd ? a[9:0] : 0;
    e.bl = !col_cmd ? 0 : a[12] ? 8 : 4;
    e.ap = col_cmd && a[10];
    e.bopen = m_open; e.orow = m_row[e.bank];
    e.mode = m_mode; e.odt = od && m_term; e.perr = err; e.tag = tag;
    if (c == 6 && b == 1) m_term = a[9] | a[6] | a[2];
    m_ckep = ck;
    q.push_back(e);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compare 1 ns after the edge that consumed the vector
  always @(posedge clk) begin
    #1;
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "R2 cmd", cmd, e.cmd);
      chk(e.tag, "R2 bank", bank, e.bank);
      chk(e.tag, "R4 col", col, e.col);
      chk(e.tag, "R5 burst", blen, e.bl);
      chk(e.tag, "R4 auto_pre", ap, e.ap);
      chk(e.tag, "R6 open", bopen, e.bopen);
      chk(e.tag, "R3 row", orow, e.orow);
      chk(e.tag, "R8 mode", pmode, e.mode);
      chk(e.tag, "R11 odt", odt_en, e.odt);
      chk(e.tag, "R7 proto_err", perr, e.perr);
      chk(e.tag, "R12 cke_err", ckerr, e.ckerr);
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=done", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // reset state
    #0.5;
    chk("R1", "reset cmd", cmd, 0);
    chk("R3", "reset open", bopen, 0);
    chk("R8", "reset mode", pmode, 0);
    chk("R11", "reset odt", odt_en, 0);
    drive("R1",  1, S_NOP, 0, 16'h0000, 1, 1);
    drive("R11", 0, S_MRS, 1, 16'h0004, 1, 1);  // enable termination
    drive("R11", 0, S_NOP, 0, 16'h0000, 1, 1);
    drive("R3",  0, S_ACT, 2, 16'hBEEF, 1, 0);
    drive("R3",  0, S_ACT, 5, 16'h1234, 1, 0);
    drive("R1",  1, S_ACT, 3, 16'h5555, 1, 0);  // masked
    drive("R7",  0, S_ACT, 2, 16'h7777, 1, 0);  // already open
    drive("R5",  0, S_RD,  2, 16'h1155, 1, 0);  // full, no auto-pre
    drive("R5",  0, S_WR,  5, 16'h02AA, 1, 0);  // chopped
    drive("R7",  0, S_RD,  0, 16'h1001, 1, 0);  // closed bank
    drive("R2",  0, S_ZQ,  4, 16'h0000, 1, 0);
    drive("R2",  0, S_NOP, 0, 16'h0000, 1, 0);
    drive("R2",  0, S_NOP, 0, 16'h0000, 1, 0);
    drive("R4",  0, S_RD,  2, 16'h1403, 1, 0);  // auto-precharge closes 2
    drive("R12", 0, S_NOP, 0, 16'h0000, 0, 0);  // drop inside window, APD
    drive("R10", 0, S_ACT, 6, 16'h0101, 0, 0);  // ignored
    drive("R10", 0, S_PRE, 5, 16'h0400, 0, 0);  // ignored
    drive("R8",  0, S_NOP, 0, 16'h0000, 1, 0);
    drive("R6",  0, S_PRE, 5, 16'h0000, 1, 0);  // single bank
    drive("R6",  0, S_ACT, 1, 16'hAAAA, 1, 0);
    drive("R6",  0, S_ACT, 6, 16'hCCCC, 1, 0);
    drive("R6",  0, S_PRE, 3, 16'h0000, 1, 0);  // closed bank, legal
    drive("R6",  0, S_PRE, 0, 16'h0400, 1, 0);  // all banks
    drive("R2",  0, S_REF, 0, 16'h0000, 1, 0);
    drive("R8",  0, S_NOP, 0, 16'h0000, 0, 0);  // PPD
    drive("R8",  0, S_NOP, 0, 16'h0000, 0, 0);
    drive("R8",  0, S_NOP, 0, 16'h0000, 1, 0);
    drive("R9",  0, S_ACT, 4, 16'h4444, 1, 0);
    drive("R9",  0, S_REF, 0, 16'h0000, 0, 0);  // refused self-refresh
    drive("R9",  0, S_NOP, 0, 16'h0000, 1, 0);
    drive("R9",  0, S_PRE, 0, 16'h0400, 1, 0);
    drive("R9",  0, S_REF, 0, 16'h0000, 0, 0);  // self-refresh
    drive("R10", 0, S_ACT, 7, 16'h9999, 0, 1);
    drive("R10", 0, S_REF, 0, 16'h0000, 0, 1);
    drive("R9",  0, S_NOP, 0, 16'h0000, 1, 1);
    drive("R11", 0, S_MRS, 2, 16'h0000, 1, 1);  // other register
    drive("R11", 0, S_NOP, 0, 16'h0000, 1, 1);
    drive("R11", 0, S_MRS, 1, 16'h0000, 1, 1);  // disable
    drive("R11", 0, S_NOP, 0, 16'h0000, 1, 1);
    drive("R12", 0, S_ACT, 3, 16'h3333, 1, 0);
    drive("R12", 0, S_WR,  3, 16'h0010, 1, 0);  // chopped: window of 2
    drive("R12", 0, S_NOP, 0, 16'h0000, 1, 0);
    drive("R12", 0, S_NOP, 0, 16'h0000, 1, 0);
    drive("R12", 0, S_NOP, 0, 16'h0000, 0, 0);  // outside window
    drive("R8",  0, S_NOP, 0, 16'h0000, 1, 0);
    repeat (3) @(posedge clk);
    #2;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule